// File: doc/BRIEF.md
# Converter Control Word and Power-State Controller

This block holds the eight-bit configuration word of a two-channel converter and turns it into the signals the rest of the chip acts on. Those signals are an operating state (running, standby or powered off), a data-path enable, an interleave flag, an external-reference flag and a four-bit gain trim code for the first channel. A new word is taken from a parallel bus on a clock edge when a load strobe is high. Otherwise the stored word is kept.

The converter needs time to wake up after it comes out of standby or power-off. For that reason the block also drives a ready flag. This flag stays low for a fixed wake-up interval of about 3 µs after the running state is re-entered. The interval is counted in clock cycles, and the count is derived from a clock-frequency parameter. The analog effects of the word are handled elsewhere. These include reference generation, current steering and the actual gain scaling.

Top module: `dacw_ctrl`

## Requirements
- R1: On a rising clock edge with `load_i` high, the word on `word_i` becomes the stored configuration, and the outputs reflect it from that edge on.
- R2: On an edge with `load_i` low, the stored configuration is unchanged, whatever value `word_i` has.
- R3: While reset is asserted and after it is released, the outputs are: `mode_o` = 0 (running), `dp_en_o` = 1, `ready_o` = 1, `gain_o` = 0, `ext_ref_o` = 0 and `interleave_o` = 0. This corresponds to a stored word of 0x40.
- R4: Bit 7 of the word is power-off. When it is 1, `mode_o` is 2 (off), whatever the other bits are.
- R5: Bit 6 of the word is the converter enable. With bit 7 at 0 and bit 6 at 0, `mode_o` is 1 (standby).
- R6: With bit 7 at 0 and bit 6 at 1, `mode_o` is 0 (running). Bit 5 appears on `interleave_o`, where 1 means the two channels' samples share one input port.
- R7: Bit 4 appears on `ext_ref_o`. A value of 0 selects the internal reference and 1 selects an external one.
- R8: Bits 3..0 appear on `gain_o` as the channel-A gain trim code. Bit 3 is the most significant.
- R9: `dp_en_o` is 1 exactly when `mode_o` is 0 (running), and 0 in standby and off.
- R10: `ready_o` is 0 in the same cycle in which `mode_o` leaves the running state.
- R11: When `mode_o` returns to running from standby or off, `ready_o` stays 0 for exactly WAKE clock edges, counted after the loading edge. WAKE = CLK_HZ × WAKE_NS / 10^9, with a minimum of 1. This is 600 at the defaults of 200 MHz and 3000 ns.
- R12: Loading a new running-state word while already running changes neither the progress of the wake-up count nor a ready flag that is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load strobe for the configuration word |
| word_i | input | 8 | Configuration word (off, enable, interleave, ext-ref, gain[3:0]) |
| mode_o | output | 2 | Operating state: 0 running, 1 standby, 2 off |
| dp_en_o | output | 1 | Data-path enable, high only when running |
| interleave_o | output | 1 | Interleaved input mode flag |
| ext_ref_o | output | 1 | External reference select |
| gain_o | output | 4 | Channel-A gain trim code |
| ready_o | output | 1 | Converter awake and usable |

## Verification
Several properties are checked on every cycle. Power-off always wins over the other bits, and a held word stays stable. Neither the data-path enable nor ready is ever high outside the running state. Ready is low on the first running cycle after a wake-up, and a ready flag that is already up survives reloads of a running word. Some behaviour is left to the bench's scenarios, which compare all outputs against a reference model on each cycle. These scenarios cover the exact length of the wake-up window after both standby and off, a reload in the middle of the window that must not restart it, and the field mapping under random words.

// File: rtl/dacw_pkg.sv
`timescale 1ns/1ps
package dacw_pkg;
  localparam int GAIN_W = 4;
  localparam int WORD_W = GAIN_W + 4;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_OFF  = 2'd2
  } pmode_e;

  typedef struct packed {
    logic              off;
    logic              enable;
    logic              ilv;
    logic              extref;
    logic [GAIN_W-1:0] gain;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{off: 1'b0, enable: 1'b1, ilv: 1'b0,
                                   extref: 1'b0, gain: '0};
endpackage

// File: rtl/dacw_cfg_reg.sv
`timescale 1ns/1ps
module dacw_cfg_reg
  import dacw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  ctrl_t d,
  output ctrl_t q
);
  ctrl_t q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= CTRL_RESET;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q_r)); // R2
  AST_WORD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q_r == $past(d))); // R1
endmodule

// File: rtl/dacw_mode_dec.sv
`timescale 1ns/1ps
module dacw_mode_dec
  import dacw_pkg::*;
(
  input  ctrl_t  w,
  output pmode_e mode
);
  // Priority: power-off first, then enable.
  always_comb begin
    if (w.off)          mode = PM_OFF;
    else if (!w.enable) mode = PM_IDLE;
    else                mode = PM_RUN;
  end
endmodule

// File: rtl/dacw_wake_tmr.sv
`timescale 1ns/1ps
module dacw_wake_tmr #(
  parameter int WAKE_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ready
);
  localparam int CNT_W = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAKE_CYC);

  logic [CNT_W-1:0] cnt_r, cnt_nxt;
  logic             cnt_en;

  // Counter is re-armed in any non-running cycle and drains while running.
  assign cnt_en = !run || (cnt_r != '0);

  always_comb begin
    cnt_nxt = cnt_r;
    if (cnt_en) begin
      if (!run) cnt_nxt = LOAD_VAL;
      else      cnt_nxt = cnt_r - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_r <= '0;
    else if (cnt_en) cnt_r <= cnt_nxt;
  end

  assign ready = run && (cnt_r == '0);

  AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> run); // R10
  AST_WAKE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> !ready); // R11
endmodule

// File: rtl/dacw_ctrl.sv
`timescale 1ns/1ps
module dacw_ctrl
  import dacw_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned WAKE_NS = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        mode_o,
  output logic              dp_en_o,
  output logic              interleave_o,
  output logic              ext_ref_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              ready_o
);
  localparam longint unsigned WAKE_RAW =
    (longint'(CLK_HZ) * longint'(WAKE_NS)) / 64'd1_000_000_000;
  localparam int WAKE_CYC = (WAKE_RAW < 64'd1) ? 1 : int'(WAKE_RAW);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_r;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_r <= 2'b00;
    else        rst_sync_r <= {rst_sync_r[0], 1'b1};
  end
  assign rst_int_n = rst_sync_r[1];

  ctrl_t  cfg_q;
  pmode_e mode;
  logic   run;
  logic   ready;

  dacw_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ld    (load_i),
    .d     (ctrl_t'(word_i)),
    .q     (cfg_q)
  );

  dacw_mode_dec u_dec (
    .w    (cfg_q),
    .mode (mode)
  );

  assign run = (mode == PM_RUN);

  dacw_wake_tmr #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .ready (ready)
  );

  assign mode_o       = mode;
  assign dp_en_o      = run;
  assign interleave_o = cfg_q.ilv;
  assign ext_ref_o    = cfg_q.extref;
  assign gain_o       = cfg_q.gain;
  assign ready_o      = ready;

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(load_i && word_i[WORD_W-1]) |-> (mode_o == 2'd2)); // R4
  AST_IDLE_DECODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(load_i && !word_i[WORD_W-1] && !word_i[WORD_W-2]) |-> (mode_o == 2'd1)); // R5
  AST_DP_GATED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_o != 2'd0) |-> (!dp_en_o && !ready_o)); // R9
  AST_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(ready_o) && (mode_o == 2'd0)) |-> ready_o); // R12
endmodule

// File: tb/tb_dacw_ctrl.sv
`timescale 1ns/1ps
module tb_dacw_ctrl;
  localparam int WAKE = 200 * 3; // 200 MHz x 3000 ns

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] word_i = 8'h00;
  logic [1:0] mode_o;
  logic       dp_en_o, interleave_o, ext_ref_o, ready_o;
  logic [3:0] gain_o;

  int n_vec = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model state
  logic [7:0] m_word;
  int         m_mode;
  int         m_wake;

  always #2.5 clk = ~clk;

  dacw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i),
    .mode_o(mode_o), .dp_en_o(dp_en_o), .interleave_o(interleave_o),
    .ext_ref_o(ext_ref_o), .gain_o(gain_o), .ready_o(ready_o)
  );

  function automatic int exp_mode(input logic [7:0] w);
    if (w[7])      return 2;
    else if (!w[6]) return 1;
    else           return 0;
  endfunction

  function automatic bit exp_ready();
    return (m_mode == 0) && (m_wake == 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string mt;
    mt = (m_mode == 2) ? "R4" : (m_mode == 1) ? "R5" : "R6";
    chk(mt,                 int'(mode_o),       m_mode);
    chk("R9",               int'(dp_en_o),      int'(m_mode == 0));
    chk("R6",               int'(interleave_o), int'(m_word[5]));
    chk("R7",               int'(ext_ref_o),    int'(m_word[4]));
    chk("R8",               int'(gain_o),       int'(m_word[3:0]));
    chk("R10 R11 R12",      int'(ready_o),      int'(exp_ready()));
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge.
  task automatic step(input logic ld, input logic [7:0] w);
    load_i = ld;
    word_i = w;
    @(posedge clk);
    if (m_mode != 0)      m_wake = WAKE;
    else if (m_wake > 0)  m_wake = m_wake - 1;
    if (ld) m_word = w;
    m_mode = exp_mode(m_word);
    @(negedge clk);
    n_vec++;
    check_all();
  endtask

  task automatic wait_ready(input string tag);
    int n;
    n = 0;
    while (!ready_o && n < WAKE + 50) begin
      step(1'b0, 8'hFF);
      n++;
    end
    chk(tag, n, WAKE);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    m_word = 8'h40;
    m_mode = 0;
    m_wake = 0;
    repeat (3) @(negedge clk);
    // R3: outputs during reset
    chk("R3", int'(mode_o), 0);
    chk("R3", int'(ready_o), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: outputs after release
    check_all();
    chk("R3", int'({dp_en_o, interleave_o, ext_ref_o, gain_o}), 7'b1000000);

    // R2: strobe low, bus noise ignored
    step(1'b0, 8'hBF);
    chk("R2", int'(gain_o), 0);
    // R1: a loaded word shows up
    step(1'b1, 8'h7A);
    chk("R1", int'({interleave_o, ext_ref_o, gain_o}), 6'b11_1010);

    // R4: power-off overrides enable
    step(1'b1, 8'hC5);
    chk("R4", int'(mode_o), 2);
    chk("R10", int'(ready_o), 0);
    // R11: wake from off
    step(1'b1, 8'h43);
    wait_ready("R11 off->run");

    // R5: standby, one cycle only, then wake
    step(1'b1, 8'h2C);
    chk("R5", int'(mode_o), 1);
    step(1'b1, 8'h41);
    // R12: reload mid-window must not restart the count
    for (int i = 0; i < 100; i++) step(1'b0, 8'h00);
    step(1'b1, 8'h6F);
    begin
      int n;
      n = 101;
      while (!ready_o && n < WAKE + 50) begin
        step(1'b0, 8'h00);
        n++;
      end
      chk("R12 R11 idle->run", n, WAKE);
    end
    // R12: reload while ready stays ready
    step(1'b1, 8'h58);
    chk("R12", int'(ready_o), 1);

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      w = 8'($urandom(32'h5EED) & 0) | 8'($urandom);
      if (($urandom % 8) != 0) w[7] = 1'b0;
      if (($urandom % 8) != 0) w[6] = 1'b1;
      step(($urandom % 6) == 0, w);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule